// File: doc/BRIEF.md
# Register-Controlled Two-Byte I2C Master

This block is an I2C bus master that a processor steers through a handful of byte-wide registers on a simple synchronous register bus. Software first writes the target's 7-bit address and a direction flag, and for a write it also writes one or two payload bytes. It then sets a single start bit. The block then runs one complete bus transaction with no further help from software. The transaction is START, then the address byte, then one or two data bytes, each followed by an acknowledge slot, then STOP.

A length bit chooses a one-byte or a two-byte transaction. Received bytes land in a primary and a secondary receive register. A busy flag shows that a transaction is in flight. An error flag records a target that refused an address or a payload byte. A completion interrupt is raised when the STOP condition has finished. The SDA and SCL lines are modelled as pull-low enables: a 1 pulls the wire low and a 0 releases it.

Top module: `i2c_xfer_master`

## Requirements
- R1: After reset, every register reads 0 except the clock divider at offset 6, which reads 4. Both bus lines are released and `irq_o` is low. Register offsets: 0 control/status, 1 target address, 2 first payload, 3 second payload, 4 first received, 5 second received, 6 divider.
- R2: Writing a 1 to control bit 1 starts a transaction. Bit 1 always reads back 0. Busy (control bit 2) is high from the cycle after the start write until the STOP condition has completed.
- R3: The first byte on the bus is the address register: bits 7..1 are the 7-bit target address and bit 0 is the direction, where 1 means read. It is sent most significant bit first.
- R4: In a write, control bit 0 = 0 sends only the first payload register. Control bit 0 = 1 sends the first payload register and then the second payload register. Each byte is sent most significant bit first.
- R5: In a read, the first received byte is stored in offset 4. When control bit 0 = 1, the second received byte is stored in offset 5. Otherwise offset 5 keeps its previous value.
- R6: In a read, the master pulls SDA low in the acknowledge slot of every received byte except the last one. It releases SDA (not-acknowledge) for the last byte.
- R7: If the acknowledge slot after the address or after a payload byte reads high, the master sets the error flag (control bit 3), sends no further bytes, issues STOP and still raises the interrupt. The next start clears the error flag.
- R8: Completion sets the interrupt flag (control bit 4), which drives `irq_o`. Writing 1 to bit 4 clears the flag. If a completion and a clearing write arrive in the same cycle, the flag stays set.
- R9: A start write that arrives while busy is ignored. No second START appears on the bus, and the running transaction keeps its byte count.
- R10: Each transaction shows exactly one START (SDA falls while SCL is high) and one STOP (SDA rises while SCL is high). Otherwise SDA changes only while SCL is low.
- R11: With divider value D, every low phase of SCL during a transaction and every high phase of SCL during a bit lasts 2·(D+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed level of the SDA wire |
| irq_o | output | 1 | Completion interrupt, level |

## Verification
The interrupt flag has two sources that can act in the same cycle: the completion pulse from the bus engine and a software write of 1 to control bit 4. The bench provokes the clash by holding a clearing write on the register bus throughout a transaction. It keeps that write in place for exactly one clock edge after busy is seen low, which is the edge on which the completion pulse reaches the register file. The flag must still read 1 once the write is withdrawn, and a later clearing write on its own must take it back to 0.

// File: rtl/i2cm_pkg.sv
// Shared constants and types for the two-byte I2C master.
// Assumes byte-wide registers and 7-bit addressing only.
package i2cm_pkg;
    localparam int BYTE_W   = 8;
    localparam int REG_AW   = 3;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);
    localparam logic [BITCNT_W-1:0] ACK_SLOT = BITCNT_W'(BYTE_W);

    // register offsets
    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] OFS_DEV  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_TXA  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_TXB  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_RXA  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_RXB  = 3'd5;
    localparam logic [REG_AW-1:0] OFS_DIV  = 3'd6;

    // control/status bit positions
    localparam int CB_LEN  = 0;
    localparam int CB_GO   = 1;
    localparam int CB_BUSY = 2;
    localparam int CB_ERR  = 3;
    localparam int CB_IRQ  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } bus_st_e;
endpackage

// File: rtl/i2cm_tick.sv
// Quarter-bit tick generator.
// Emits one tick every (div+1) clocks while enabled; the count restarts when disabled.
module i2cm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    // count system clocks between quarter-bit ticks
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2cm_regs.sv
// Register file of the I2C master: configuration, payload, received bytes and status.
// Assumes DIV_W <= 8. A start is accepted only while the engine is idle.
module i2cm_regs import i2cm_pkg::*; #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              nack,
    input  logic              rx_we0,
    input  logic              rx_we1,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              go,
    output logic              go_len,
    output logic [BYTE_W-1:0] dev,
    output logic [BYTE_W-1:0] txa,
    output logic [BYTE_W-1:0] txb,
    output logic [DIV_W-1:0]  div,
    output logic              irq
);
    logic [BYTE_W-1:0] rxa_q, rxb_q;
    logic              len_q, err_q, irq_q;
    logic              ctrl_wr;

    assign ctrl_wr = we && (addr == OFS_CTRL);
    assign go      = ctrl_wr && wdata[CB_GO] && !busy;
    assign go_len  = wdata[CB_LEN];
    assign irq     = irq_q;

    // software-written configuration and payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev   <= '0;
            txa   <= '0;
            txb   <= '0;
            len_q <= 1'b0;
            div   <= DIV_W'(DIV_RST);
        end else if (we) begin
            unique case (addr)
                OFS_CTRL: len_q <= wdata[CB_LEN];
                OFS_DEV:  dev   <= wdata;
                OFS_TXA:  txa   <= wdata;
                OFS_TXB:  txb   <= wdata;
                OFS_DIV:  div   <= wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    // capture received bytes from the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxa_q <= '0;
            rxb_q <= '0;
        end else begin
            if (rx_we0) rxa_q <= rx_byte;
            if (rx_we1) rxb_q <= rx_byte;
        end
    end

    // status flags: the error flag clears on start, completion wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (go)        err_q <= 1'b0;
            else if (nack) err_q <= 1'b1;
            if (done)                         irq_q <= 1'b1;
            else if (ctrl_wr && wdata[CB_IRQ]) irq_q <= 1'b0;
        end
    end

    // read multiplexer
    always_comb begin
        unique case (addr)
            OFS_CTRL: rdata = {3'b000, irq_q, err_q, busy, 1'b0, len_q};
            OFS_DEV:  rdata = dev;
            OFS_TXA:  rdata = txa;
            OFS_TXB:  rdata = txb;
            OFS_RXA:  rdata = rxa_q;
            OFS_RXB:  rdata = rxb_q;
            OFS_DIV:  rdata = BYTE_W'(div);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cm_engine.sv
// Bus sequencer: START, address byte, one or two data bytes with acknowledge slots, STOP.
// Each bit takes four ticks: SCL low, SDA update, SCL high, SCL high after the sample.
// Assumes no clock stretching and a single master on the bus.
module i2cm_engine import i2cm_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_len,
    input  logic [BYTE_W-1:0] dev,
    input  logic [BYTE_W-1:0] txa,
    input  logic [BYTE_W-1:0] txb,
    input  logic              tick,
    input  logic              sda_in,
    output logic              busy,
    output logic              done,
    output logic              nack,
    output logic              rx_we0,
    output logic              rx_we1,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_low,
    output logic              sda_low
);
    bus_st_e             st_q;
    logic [1:0]          ph_q, byte_q;
    logic [BITCNT_W-1:0] bit_q;
    logic [BYTE_W-1:0]   sh_q, tb_q;
    logic                rd_q, len_q, ack_q;
    logic                tx_byte, ack_slot, byte_end;
    logic [1:0]          last_byte;

    assign last_byte = len_q ? 2'd2 : 2'd1;
    assign tx_byte   = (byte_q == 2'd0) || !rd_q;
    assign ack_slot  = (bit_q == ACK_SLOT);
    assign byte_end  = tick && (st_q == ST_BITS) && (ph_q == 2'd3) && ack_slot;
    assign rx_we0    = byte_end && !tx_byte && (byte_q == 2'd1);
    assign rx_we1    = byte_end && !tx_byte && (byte_q == 2'd2);
    assign rx_byte   = sh_q;
    assign busy      = (st_q != ST_IDLE);

    // transaction sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            ph_q    <= '0;
            byte_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            tb_q    <= '0;
            rd_q    <= 1'b0;
            len_q   <= 1'b0;
            ack_q   <= 1'b0;
            done    <= 1'b0;
            nack    <= 1'b0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            done <= 1'b0;
            nack <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (go) begin
                    st_q   <= ST_START;
                    ph_q   <= '0;
                    byte_q <= '0;
                    bit_q  <= '0;
                    sh_q   <= dev;
                    tb_q   <= txb;
                    rd_q   <= dev[0];
                    len_q  <= go_len;
                end
                ST_START: if (tick) begin
                    if (ph_q == 2'd0) begin
                        ph_q    <= 2'd1;
                        sda_low <= 1'b1;
                    end else begin
                        st_q    <= ST_BITS;
                        ph_q    <= '0;
                        scl_low <= 1'b1;
                    end
                end
                ST_BITS: if (tick) begin
                    ph_q <= ph_q + 1'b1;
                    unique case (ph_q)
                        2'd0: begin
                            if (ack_slot) sda_low <= tx_byte ? 1'b0 : (byte_q != last_byte);
                            else          sda_low <= tx_byte ? ~sh_q[BYTE_W-1] : 1'b0;
                        end
                        2'd1: scl_low <= 1'b0;
                        2'd2: begin
                            if (ack_slot)      ack_q <= sda_in;
                            else if (!tx_byte) sh_q  <= {sh_q[BYTE_W-2:0], sda_in};
                        end
                        default: begin
                            scl_low <= 1'b1;
                            if (!ack_slot) begin
                                bit_q <= bit_q + 1'b1;
                                if (tx_byte) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                            end else begin
                                bit_q <= '0;
                                if (tx_byte && ack_q) begin
                                    nack <= 1'b1;
                                    st_q <= ST_STOP;
                                end else if (byte_q == last_byte) begin
                                    st_q <= ST_STOP;
                                end else begin
                                    byte_q <= byte_q + 1'b1;
                                    sh_q   <= (byte_q == 2'd0) ? txa : tb_q;
                                end
                            end
                        end
                    endcase
                end
                ST_STOP: if (tick) begin
                    ph_q <= ph_q + 1'b1;
                    unique case (ph_q)
                        2'd0: sda_low <= 1'b1;
                        2'd1: scl_low <= 1'b0;
                        2'd2: sda_low <= 1'b0;
                        default: begin
                            st_q <= ST_IDLE;
                            done <= 1'b1;
                        end
                    endcase
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_xfer_master.sv
// Top level of the register-controlled I2C master: register file, tick divider, bus engine.
// Assumes the bus lines have external pull-ups; outputs are pull-low enables.
module i2c_xfer_master import i2cm_pkg::*; #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              scl_low_o,
    output logic              sda_low_o,
    input  logic              sda_i,
    output logic              irq_o
);
    logic              go, go_len, tick;
    logic              eng_busy, eng_done, eng_nack, rx_we0, rx_we1;
    logic [BYTE_W-1:0] dev, txa, txb, rx_byte;
    logic [DIV_W-1:0]  div;

    i2cm_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(eng_busy), .done(eng_done), .nack(eng_nack),
        .rx_we0(rx_we0), .rx_we1(rx_we1), .rx_byte(rx_byte), .go(go), .go_len(go_len),
        .dev(dev), .txa(txa), .txb(txb), .div(div), .irq(irq_o)
    );

    i2cm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(eng_busy), .div(div), .tick(tick)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .go_len(go_len), .dev(dev), .txa(txa),
        .txb(txb), .tick(tick), .sda_in(sda_i), .busy(eng_busy), .done(eng_done),
        .nack(eng_nack), .rx_we0(rx_we0), .rx_we1(rx_we1), .rx_byte(rx_byte),
        .scl_low(scl_low_o), .sda_low(sda_low_o)
    );
endmodule

// File: rtl/i2cm_xfer_chk.sv
// Protocol checker for the I2C master, attached to the top through bind.
module i2cm_xfer_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_low,
    input logic sda_low,
    input logic busy,
    input logic go,
    input logic done,
    input logic irq
);
    // R10
    sda_hold_on_scl_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low != $past(scl_low)) |-> $stable(sda_low));

    // R10
    idle_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_low && !sda_low));

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    // R2
    start_makes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R8
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done));
endmodule

bind i2c_xfer_master i2cm_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_low(scl_low_o), .sda_low(sda_low_o),
    .busy(eng_busy), .go(go), .done(eng_done), .irq(irq_o)
);

// File: tb/i2c_xfer_master_bench.sv
module i2c_xfer_master_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       we;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       scl_low, sda_low, irq;
    logic       s_low = 1'b0;
    wire        scl_line = ~scl_low;
    wire        sda_line = ~(sda_low | s_low);

    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    i2c_xfer_master u_i2c_xfer_master (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .scl_low_o(scl_low), .sda_low_o(sda_low), .sda_i(sda_line),
        .irq_o(irq)
    );

    // ---------------- target model ----------------
    localparam logic [6:0] S_ADDR = 7'h2A;
    int         s_nack_byte = -1;
    logic [7:0] s_tx [0:3];
    logic [7:0] s_rx [0:3];
    logic       s_mack [0:3];
    int         s_nbytes = 0;
    int         s_cnt = 0, s_bno = 0;
    logic [7:0] s_sh = 0, s_txsh = 0;
    logic       s_rw = 0, s_match = 0, s_sending = 0;
    logic       p_scl = 1, p_sda = 1;

    always @(scl_line or sda_line) begin
        if (scl_line && p_scl && !sda_line && p_sda) begin
            s_cnt = 0; s_bno = 0; s_sending = 0; s_low = 0; s_nbytes = 0;
            for (int i = 0; i < 4; i++) s_mack[i] = 1'b1;
        end else if (scl_line && p_scl && sda_line && !p_sda) begin
            s_cnt = 0; s_sending = 0;
        end else if (scl_line && !p_scl) begin
            if (s_cnt < 8) begin
                if (s_bno == 0 || !s_rw) s_sh = {s_sh[6:0], sda_line};
                s_cnt++;
            end else if (s_cnt == 8) begin
                if (s_bno > 0 && s_rw && s_bno < 4) s_mack[s_bno] = sda_line;
                s_cnt = 9;
            end
        end else if (!scl_line && p_scl) begin
            if (s_cnt == 8) begin
                s_nbytes++;
                if (s_bno == 0) begin
                    s_rx[0] = s_sh; s_rw = s_sh[0]; s_match = (s_sh[7:1] == S_ADDR);
                    s_low = s_match && (s_nack_byte != 0);
                end else if (!s_rw) begin
                    if (s_bno < 4) s_rx[s_bno] = s_sh;
                    s_low = s_match && (s_nack_byte != s_bno);
                end else s_low = 0;
            end else if (s_cnt == 9) begin
                s_low = 0; s_cnt = 0; s_sending = 0; s_bno++;
                if (s_rw && s_match && s_bno < 4 && (s_bno == 1 || s_mack[s_bno-1] == 1'b0)) begin
                    s_sending = 1; s_txsh = s_tx[s_bno]; s_low = ~s_txsh[7];
                end
            end else if (s_cnt >= 1 && s_cnt <= 7 && s_sending) begin
                s_low = ~s_txsh[7-s_cnt];
            end
        end
        p_scl = scl_line; p_sda = sda_line;
    end

    // ---------------- bus monitor (R10, R11) ----------------
    int mon_starts = 0, mon_stops = 0, hi_good = 0, lo_runs = 0, lo_bad = 0;
    int hi_len = 0, lo_len = 0, exp_half = 10;
    logic m_scl = 0, m_sda = 0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!scl_low && !m_scl && (sda_low != m_sda)) begin
                if (sda_low) mon_starts++; else mon_stops++;
            end
            if (!scl_low) begin
                if (m_scl) begin
                    lo_runs++; if (lo_len != exp_half) lo_bad++;
                    hi_len = 1;
                end else hi_len++;
            end else begin
                if (!m_scl) begin
                    if (hi_len == exp_half) hi_good++;
                    lo_len = 1;
                end else lo_len++;
            end
            m_scl = scl_low; m_sda = sda_low;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        we = 1; addr = a; wdata = d;
        @(negedge clk);
        we = 0; addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata; addr = 3'd0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd0, v);
            if (!v[2]) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    int b_st, b_sp, b_hg, b_lr, b_lb;
    task automatic mark();
        b_st = mon_starts; b_sp = mon_stops; b_hg = hi_good; b_lr = lo_runs; b_lb = lo_bad;
    endtask

    task automatic set_div(input int d);
        wr(3'd6, 8'(d)); exp_half = 2 * (d + 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reg %0d after reset", a), v, (a == 6) ? 4 : 0);
        end
        chk("R1 lines released", {scl_low, sda_low}, 0);
        chk("R1 irq low", irq, 0);
    endtask

    task automatic t_write1();
        logic [7:0] v;
        set_div(1);
        wr(3'd1, {S_ADDR, 1'b0}); wr(3'd2, 8'hA5);
        mark();
        wr(3'd0, 8'h02);
        rd(3'd0, v);
        chk("R2 start bit reads 0", v[1], 0);
        chk("R2 busy after start", v[2], 1);
        wait_idle();
        chk("R3 address byte", s_rx[0], {S_ADDR, 1'b0});
        chk("R4 one-byte payload", s_rx[1], 8'hA5);
        chk("R4 one-byte count", s_nbytes, 2);
        chk("R10 one START", mon_starts - b_st, 1);
        chk("R10 one STOP", mon_stops - b_sp, 1);
        chk("R11 SCL high runs at D=1", hi_good - b_hg, 18);
        chk("R11 SCL low runs at D=1", lo_runs - b_lr, 19);
        chk("R11 SCL low length D=1", lo_bad - b_lb, 0);
        rd(3'd0, v);
        chk("R8 irq flag set", v[4], 1);
        chk("R8 irq pin set", irq, 1);
        chk("R7 no error on ack", v[3], 0);
        wr(3'd0, 8'h10);
        chk("R8 irq cleared by W1C", irq, 0);
    endtask

    task automatic t_write2();
        set_div(3);
        wr(3'd1, {S_ADDR, 1'b0}); wr(3'd2, 8'h3C); wr(3'd3, 8'hC3);
        mark();
        wr(3'd0, 8'h03);
        wait_idle();
        chk("R4 two-byte first", s_rx[1], 8'h3C);
        chk("R4 two-byte second", s_rx[2], 8'hC3);
        chk("R4 two-byte count", s_nbytes, 3);
        chk("R11 SCL high runs at D=3", hi_good - b_hg, 27);
        chk("R11 SCL low length D=3", lo_bad - b_lb, 0);
        chk("R10 START/STOP two-byte", (mon_starts - b_st) * 10 + (mon_stops - b_sp), 11);
        wr(3'd0, 8'h10);
    endtask

    task automatic t_read();
        logic [7:0] v;
        set_div(1);
        s_tx[1] = 8'h81; s_tx[2] = 8'h7E;
        wr(3'd1, {S_ADDR, 1'b1});
        wr(3'd0, 8'h03);
        wait_idle();
        chk("R3 read address byte", s_rx[0], {S_ADDR, 1'b1});
        rd(3'd4, v); chk("R5 first received", v, 8'h81);
        rd(3'd5, v); chk("R5 second received", v, 8'h7E);
        chk("R6 ack after byte 1", s_mack[1], 0);
        chk("R6 nack after last of 2", s_mack[2], 1);
        wr(3'd0, 8'h10);
        s_tx[1] = 8'h42; s_tx[2] = 8'hEE;
        wr(3'd0, 8'h02);
        wait_idle();
        rd(3'd4, v); chk("R5 one-byte read RXA", v, 8'h42);
        rd(3'd5, v); chk("R5 RXB kept", v, 8'h7E);
        chk("R6 nack after single byte", s_mack[1], 1);
        wr(3'd0, 8'h10);
    endtask

    task automatic t_nack();
        logic [7:0] v;
        mark();
        wr(3'd1, 8'h40); wr(3'd2, 8'h11); wr(3'd3, 8'h22);
        wr(3'd0, 8'h03);
        wait_idle();
        rd(3'd0, v);
        chk("R7 address nack error", v[3], 1);
        chk("R7 address nack irq", v[4], 1);
        chk("R7 no bytes after address", s_nbytes, 1);
        chk("R7 STOP after nack", mon_stops - b_sp, 1);
        wr(3'd0, 8'h10);
        s_nack_byte = 1;
        wr(3'd1, {S_ADDR, 1'b0});
        wr(3'd0, 8'h03);
        wait_idle();
        rd(3'd0, v);
        chk("R7 data nack error", v[3], 1);
        chk("R7 second byte skipped", s_nbytes, 2);
        wr(3'd0, 8'h10);
        s_nack_byte = -1;
        wr(3'd0, 8'h02);
        rd(3'd0, v);
        chk("R7 error cleared by start", v[3], 0);
        wait_idle();
        wr(3'd0, 8'h10);
    endtask

    task automatic t_busy_start();
        mark();
        wr(3'd1, {S_ADDR, 1'b0}); wr(3'd2, 8'h5A);
        wr(3'd0, 8'h02);
        repeat (20) @(negedge clk);
        wr(3'd0, 8'h03);
        wait_idle();
        repeat (60) @(negedge clk);
        chk("R9 single START", mon_starts - b_st, 1);
        chk("R9 byte count kept", s_nbytes, 2);
        wr(3'd0, 8'h10);
    endtask

    task automatic t_irq_collide();
        logic [7:0] v;
        wr(3'd1, {S_ADDR, 1'b0});
        wr(3'd0, 8'h02);
        we = 1; addr = 3'd0; wdata = 8'h10;
        for (int i = 0; i < 20000; i++) begin
            #1;
            if (!rdata[2]) break;
            @(negedge clk);
        end
        @(negedge clk);
        we = 0;
        #1;
        chk("R8 set wins over clear", irq, 1);
        wr(3'd0, 8'h10);
        rd(3'd0, v);
        chk("R8 later clear", v[4], 0);
    endtask

    task automatic finish_sim();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0; we = 0; addr = 0; wdata = 0;
        for (int i = 0; i < 4; i++) begin s_tx[i] = 0; s_rx[i] = 0; s_mack[i] = 1; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write1();
        t_write2();
        t_read();
        t_nack();
        t_busy_start();
        t_irq_collide();
        finish_sim();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end
endmodule